// File: doc/BRIEF.md
# Inductive-Reuse Dependence Queue

This block is an eight-deep queue placed between a producing compute region and a consuming compute region. Each value the producer hands over is shown to the consumer several times in a row before it leaves the queue. The number of showings is not fixed. It falls as an outer loop advances, which matches a triangular dependence in which every later outer step needs one value fewer times than the step before it. No software synchronisation is involved: the two sides meet only through the valid/ready handshakes.

A plain control pin `run_start` starts a new outer loop by clearing the internal outer-iteration index. Every accepted push is one outer step and advances the index by one. The index saturates at its maximum value. The reuse count of a pushed value is `cfg_init - index * cfg_step`, taken from the configuration pins in the cycle of the push. A value whose count is zero or less is accepted and then discarded.

Both data sides use valid/ready handshakes. A transfer takes place in a cycle in which valid and ready are both high. The producer must hold `in_valid` and `in_data` until `in_ready` is high. The consumer may hold `out_ready` low for any length of time. While it does, the head value, its last-use flag and `out_valid` stay unchanged. `in_ready` depends combinationally on `out_ready`. This allows a push into a full queue in the same cycle as the final read of the head.

Top module: `inductive_reuse_fifo`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: A value pushed as the k-th accepted push since `run_start` (the first push has k = 0) is presented in exactly `cfg_init - k*cfg_step` consecutive output transfers when that number is positive.
- R3: A push whose computed count is zero or negative is accepted but never presented, and it still advances the outer index.
- R4: `out_last` is 1 on the final presentation of each value and 0 on all the earlier ones. The value is removed on that final transfer.
- R5: Values that are kept appear at the output in the order in which they were pushed.
- R6: The queue holds at most 8 values. With 8 stored, `in_ready` is 0 unless the head is being read for the last time in that cycle, in which case a push is accepted in that same cycle.
- R7: `out_valid` is 0 when the queue is empty. While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_last` and `out_valid` hold.
- R8: `run_start` clears the outer index. A push in the same cycle uses index 0.
- R9: The configuration is sampled at push time. Changing `cfg_init` or `cfg_step` does not alter values already stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_start | input | 1 | Clears the outer-iteration index |
| cfg_init | input | 8 | Reuse count at outer index 0 |
| cfg_step | input | 8 | Amount the reuse count falls per outer step |
| in_valid | input | 1 | Producer has a value |
| in_ready | output | 1 | Queue accepts a value this cycle |
| in_data | input | 8 | Produced value |
| out_valid | output | 1 | Head value is available |
| out_ready | input | 1 | Consumer takes the head this cycle |
| out_data | output | 8 | Head value |
| out_last | output | 1 | This presentation is the head's final one |

## Verification
The assertions assume that `out_ready` is a clean signal with a known value in every cycle, and that configuration values never give a stored count wider than 8 bits. The second point holds by construction, because a count never exceeds `cfg_init`. The bench changes inputs only half a cycle away from the active clock edge and keeps `in_valid` and `in_data` steady until the push is taken. This satisfies the producer's obligation under the handshake. The sweep varies initial count, step and the gaps on both sides, including configurations where every value is dropped.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
  localparam int unsigned IFQ_DEPTH = 8;
  localparam int unsigned IFQ_DATA_W = 8;
  localparam int unsigned IFQ_CNT_W = 8;
  localparam int unsigned IFQ_IDX_W = 8;

  function automatic int unsigned ptr_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/ifq_count_calc.sv
module ifq_count_calc #(
  parameter int unsigned CW = 8,
  parameter int unsigned IW = 8
) (
  input  logic [CW-1:0] init_cnt,
  input  logic [CW-1:0] step,
  input  logic [IW-1:0] idx,
  output logic [CW-1:0] count,
  output logic          keep
);
  localparam int unsigned PW = CW + IW;
  logic [PW-1:0] prod;
  logic [PW-1:0] wide_init;

  always_comb begin
    prod      = PW'(idx) * PW'(step);
    wide_init = PW'(init_cnt);
    keep      = wide_init > prod;
    count     = init_cnt - prod[CW-1:0];
  end
endmodule

// File: rtl/ifq_iter_track.sv
module ifq_iter_track #(
  parameter int unsigned IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step_en,
  output logic [IW-1:0] cur_idx
);
  localparam logic [IW-1:0] IDX_MAX = {IW{1'b1}};
  logic [IW-1:0] idx_q;

  assign cur_idx = restart ? '0 : idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (step_en) begin
      idx_q <= (cur_idx == IDX_MAX) ? cur_idx : cur_idx + 1'b1;
    end else begin
      idx_q <= cur_idx;
    end
  end
endmodule

// File: rtl/ifq_storage.sv
module ifq_storage #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW = 8,
  parameter int unsigned CW = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic [CW-1:0]                push_cnt,
  input  logic                         pop,
  output logic [DW-1:0]                head_data,
  output logic [CW-1:0]                head_cnt,
  output logic [$clog2(DEPTH+1)-1:0]   occ,
  output logic                         full,
  output logic                         empty
);
  localparam int unsigned AW = ifq_pkg::ptr_width(DEPTH);
  localparam int unsigned OW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  logic [DW-1:0] data_mem [DEPTH];
  logic [CW-1:0] cnt_mem  [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [OW-1:0] occ_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  assign occ       = occ_q;
  assign full      = (occ_q == OW'(DEPTH));
  assign empty     = (occ_q == '0);
  assign head_data = data_mem[rd_ptr];
  assign head_cnt  = cnt_mem[rd_ptr];

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_mem[s] <= '0;
        cnt_mem[s]  <= '0;
      end else if (push && wr_ptr == AW'(s)) begin
        data_mem[s] <= push_data;
        cnt_mem[s]  <= push_cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
    end
  end
endmodule

// File: rtl/ifq_head_ctrl.sv
module ifq_head_ctrl #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          head_valid,
  input  logic [CW-1:0] head_cnt,
  input  logic          take,
  output logic          last_use,
  output logic          pop
);
  logic [CW-1:0] used_q;
  logic          fire;

  assign fire     = head_valid && take;
  assign last_use = head_valid && (used_q == head_cnt - 1'b1);
  assign pop      = fire && last_use;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (pop) begin
      used_q <= '0;
    end else if (fire) begin
      used_q <= used_q + 1'b1;
    end
  end
endmodule

// File: rtl/inductive_reuse_fifo.sv
module inductive_reuse_fifo #(
  parameter int unsigned DEPTH = ifq_pkg::IFQ_DEPTH,
  parameter int unsigned DW    = ifq_pkg::IFQ_DATA_W,
  parameter int unsigned CW    = ifq_pkg::IFQ_CNT_W,
  parameter int unsigned IW    = ifq_pkg::IFQ_IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_start,
  input  logic [CW-1:0] cfg_init,
  input  logic [CW-1:0] cfg_step,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last
);
  localparam int unsigned OW = $clog2(DEPTH + 1);

  logic [IW-1:0] cur_idx;
  logic [CW-1:0] new_cnt;
  logic          new_keep;
  logic          in_fire;
  logic          store;
  logic          pop;
  logic          full, empty;
  logic [CW-1:0] head_cnt;
  logic [OW-1:0] occ;

  assign in_ready  = !full || pop;
  assign in_fire   = in_valid && in_ready;
  assign store     = in_fire && new_keep;
  assign out_valid = !empty;

  ifq_iter_track #(.IW(IW)) u_iter (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (run_start),
    .step_en (in_fire),
    .cur_idx (cur_idx)
  );

  ifq_count_calc #(.CW(CW), .IW(IW)) u_calc (
    .init_cnt (cfg_init),
    .step     (cfg_step),
    .idx      (cur_idx),
    .count    (new_cnt),
    .keep     (new_keep)
  );

  ifq_storage #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (store),
    .push_data (in_data),
    .push_cnt  (new_cnt),
    .pop       (pop),
    .head_data (out_data),
    .head_cnt  (head_cnt),
    .occ       (occ),
    .full      (full),
    .empty     (empty)
  );

  ifq_head_ctrl #(.CW(CW)) u_head (
    .clk        (clk),
    .rst_n      (rst_n),
    .head_valid (out_valid),
    .head_cnt   (head_cnt),
    .take       (out_ready),
    .last_use   (out_last),
    .pop        (pop)
  );
endmodule

// File: rtl/ifq_checker.sv
module ifq_checker #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       in_ready,
  input logic                       out_valid,
  input logic                       out_ready,
  input logic [DW-1:0]              out_data,
  input logic                       out_last,
  input logic [$clog2(DEPTH+1)-1:0] occ
);
  localparam int unsigned OW = $clog2(DEPTH + 1);

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));

  // R6
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OW'(DEPTH) && !(out_valid && out_ready && out_last)) |-> !in_ready);

  // R7
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !out_valid);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  // R4
  reuse_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (out_valid && $stable(out_data)));
endmodule

bind inductive_reuse_fifo ifq_checker #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .occ       (occ)
);

// File: tb/tb_inductive_reuse_fifo.sv
module tb_inductive_reuse_fifo;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_start = 1'b0;
  logic [7:0] cfg_init = '0;
  logic [7:0] cfg_step = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_data;
  logic       out_last;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [7:0] exp_d [256];
  logic       exp_l [256];
  int exp_n = 0;
  int got = 0;

  inductive_reuse_fifo dut (
    .clk(clk), .rst_n(rst_n), .run_start(run_start),
    .cfg_init(cfg_init), .cfg_step(cfg_step),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog (R5): actual %0d cycles, expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic add_exp(input logic [7:0] d, input int c);
    for (int r = 0; r < c; r++) begin
      exp_d[exp_n] = d;
      exp_l[exp_n] = (r == c - 1);
      exp_n++;
    end
  endtask

  task automatic cyc(input logic iv, input logic [7:0] id, input logic ordy,
                     input logic rs, output logic acc);
    @(negedge clk);
    in_valid = iv; in_data = id; out_ready = ordy; run_start = rs;
    #1;
    acc = iv && in_ready;
    if (out_valid && ordy) begin
      if (got >= exp_n) begin
        check("R2 extra read", 1, 0);
      end else begin
        check("R5 data order", int'(out_data), int'(exp_d[got]));
        check("R4 last flag", int'(out_last), int'(exp_l[got]));
      end
      got++;
    end
  endtask

  initial begin
    logic acc;
    int naccept;
    int pushed;
    int lim;
    int base;
    #1;
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 in_ready in reset", int'(in_ready), 1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);

    // R6 / R7 / R9: fill to capacity while the consumer stalls
    cfg_init = 8'd3; cfg_step = 8'd0;
    exp_n = 0; got = 0; naccept = 0;
    cyc(1'b0, 8'd0, 1'b0, 1'b1, acc);
    for (int k = 0; k < 10; k++) begin
      cyc(1'b1, 8'(100 + naccept), 1'b0, 1'b0, acc);
      if (acc) naccept++;
    end
    check("R6 accepted before full", naccept, 8);
    check("R6 in_ready when full", int'(in_ready), 0);
    check("R7 head held under stall", int'(out_data), 100);
    for (int k = 0; k < 8; k++) add_exp(8'(100 + k), 3);
    cfg_init = 8'd20; cfg_step = 8'd2;
    add_exp(8'd200, 4);
    cyc(1'b1, 8'd200, 1'b1, 1'b0, acc);
    check("R6 no push full non-final read", int'(acc), 0);
    cyc(1'b1, 8'd200, 1'b1, 1'b0, acc);
    check("R6 no push full non-final read", int'(acc), 0);
    cyc(1'b1, 8'd200, 1'b1, 1'b0, acc);
    check("R6 push with final read when full", int'(acc), 1);
    for (int k = 0; k < 40; k++) cyc(1'b0, 8'd0, 1'b1, 1'b0, acc);
    check("R9 total reads after config change", got, exp_n);
    check("R7 empty after drain", int'(out_valid), 0);

    // R2 / R3 / R8: sweep initial count, step and handshake gaps
    for (int ii = 0; ii < 5; ii++) begin
      for (int ss = 0; ss < 3; ss++) begin
        cfg_init = 8'(ii); cfg_step = 8'(ss);
        base = ii * 40 + ss * 8;
        exp_n = 0; got = 0; pushed = 0; lim = 0;
        for (int k = 0; k < 6; k++) begin
          if (ii - k * ss > 0) add_exp(8'(base + k), ii - k * ss);
        end
        while ((pushed < 6 || got < exp_n) && lim < 300) begin
          cyc((pushed < 6) && (((lim + ii) % 4) != 3), 8'(base + pushed),
              ((lim + ss) % 3) != 0, lim == 0, acc);
          if (acc) pushed++;
          lim++;
        end
        check("R8 pushes accepted", pushed, 6);
        check("R2 reads per config", got, exp_n);
        for (int k = 0; k < 3; k++) cyc(1'b0, 8'd0, 1'b1, 1'b0, acc);
        check("R3 nothing left after drops", int'(out_valid), 0);
        check("R3 no stray reads", got, exp_n);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule